// File: doc/BRIEF.md
# Leading-One Aligned Iterative Divider

This block divides one unsigned integer by another and returns the quotient, rounded down, and the remainder. It holds one operation at a time. A two-state controller waits in its idle state until `in_valid` is high. It then captures both operands, clears the quotient and moves to its compute state.

On each compute cycle the block finds the highest set bit of the running remainder and of the divisor. It shifts the divisor so that both highest set bits line up. If the shifted divisor is then larger than the remainder, it uses one position less. It subtracts the shifted divisor and sets the matching quotient bit. A run of zero quotient bits therefore costs no cycles, so a division takes one cycle per set quotient bit plus one final cycle.

When the remainder falls below the divisor, the block raises `out_valid` for a single cycle and returns to idle. A zero divisor is finished on the first compute cycle with a saturated quotient. The result outputs are driven straight from the working registers. They are meaningful only while `out_valid` is high.

Top module: `lopdiv_top`

## Requirements
- R1: In the idle state, a cycle with `in_valid` high captures `dividend` and `divisor`, clears the quotient to 0 and enters the compute state. A result is never influenced by any earlier operation.
- R2: For a nonzero divisor, the reported quotient is floor(dividend / divisor) and the reported remainder is dividend − quotient × divisor.
- R3: Every compute cycle that starts with remainder ≥ divisor (nonzero divisor) sets exactly one quotient bit that was clear. In that same cycle it strictly decreases the remainder, which never wraps below zero. The bit is placed by the leading-one positions of the remainder and the divisor, one position lower if the aligned divisor overshoots.
- R4: `out_valid` rises at the clock edge that is popcount(quotient) + 1 edges after the accepting edge. For a zero divisor it rises 1 edge after the accepting edge.
- R5: `out_valid` is high for exactly one cycle, and in that cycle the controller is back in its idle state.
- R6: While the block is computing, `in_valid`, `dividend` and `divisor` are ignored. Changing them does not alter the result or its timing.
- R7: A zero divisor yields an all-ones quotient and a remainder equal to the dividend.
- R8: A dividend smaller than the divisor (including a zero dividend) yields quotient 0 and remainder equal to the dividend, one edge after acceptance.
- R9: Asserting `rst_n` low (asynchronous, active low) forces the idle state and clears `out_valid` at once. An operation in progress is abandoned and produces no `out_valid`.
- R10: A new operation offered in the same cycle that `out_valid` is high is accepted and computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released in step with `clk` |
| in_valid | input | 1 | Offers a new operand pair; accepted only when idle |
| dividend | input | DATA_W | Unsigned dividend |
| divisor | input | DATA_W | Unsigned divisor |
| out_valid | output | 1 | One-cycle pulse marking a finished result |
| quotient | output | DATA_W | Quotient; valid while `out_valid` is high |
| remainder | output | DATA_W | Remainder; valid while `out_valid` is high |

## Verification
The result of an accepted pair is due exactly popcount(quotient)+1 edges after the accepting edge, or one edge after it for a zero divisor. The bench counts edges from acceptance and compares that count with the figure it derives from its own quotient. It then compares quotient and remainder in the same cycle, and checks that `out_valid` is low one cycle later. All sampling takes place on the falling edge, and new inputs are applied there too, so each register stage between the inputs and `out_valid` is counted exactly once.

// File: rtl/lopdiv_pkg.sv
package lopdiv_pkg;

  // Controller states: waiting for operands, or iterating on them.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_COMP = 1'b1
  } div_state_e;

endpackage

// File: rtl/lead_one_pos.sv
// Reports the index of the highest set bit of a vector, plus a flag that
// tells whether any bit is set at all.
module lead_one_pos #(
  parameter int VEC_W = 16,
  localparam int POS_W = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
  input  logic [VEC_W-1:0] vec,
  output logic [POS_W-1:0] pos,
  output logic             found
);

  always_comb begin
    pos   = '0;
    found = 1'b0;
    // Ascending scan: the last set bit seen is the most significant one.
    for (int i = 0; i < VEC_W; i++) begin
      if (vec[i]) begin
        pos   = POS_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lopdiv_step.sv
// One reduction step, purely combinational. It aligns the divisor under the
// remainder by their leading-one positions, backs off one place on overshoot,
// and returns the reduced remainder and the one-hot quotient bit.
module lopdiv_step #(
  parameter int DATA_W = 16,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rem,
  input  logic [DATA_W-1:0] dvs,
  output logic [DATA_W-1:0] rem_next,
  output logic [DATA_W-1:0] qbit,
  output logic              fits,
  output logic              dvs_zero
);

  logic [POS_W-1:0]  rem_pos;
  logic [POS_W-1:0]  dvs_pos;
  logic              rem_found;
  logic              dvs_found;
  logic [POS_W-1:0]  shift_raw;
  logic [POS_W-1:0]  shift_fin;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] sub_val;
  logic              overshoot;

  lead_one_pos #(.VEC_W(DATA_W)) u_lop_rem (
    .vec   (rem),
    .pos   (rem_pos),
    .found (rem_found)
  );

  lead_one_pos #(.VEC_W(DATA_W)) u_lop_dvs (
    .vec   (dvs),
    .pos   (dvs_pos),
    .found (dvs_found)
  );

  always_comb begin
    dvs_zero  = !dvs_found;
    fits      = dvs_found && rem_found && (rem >= dvs);
    // When fits is set, rem_pos >= dvs_pos, so the difference does not wrap.
    shift_raw = rem_pos - dvs_pos;
    aligned   = dvs << shift_raw;
    // An overshoot is only possible with shift_raw >= 1, so the aligned value
    // has a clear low bit and halving it is exact.
    overshoot = aligned > rem;
    shift_fin = overshoot ? (shift_raw - POS_W'(1)) : shift_raw;
    sub_val   = overshoot ? (aligned >> 1) : aligned;
    rem_next  = rem - sub_val;
    qbit      = {{(DATA_W-1){1'b0}}, 1'b1} << shift_fin;
  end

endmodule

// File: rtl/lopdiv_ctrl.sv
// Two-state sequencer: captures work in idle, iterates in compute, and
// registers the completion pulse.
module lopdiv_ctrl
  import lopdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       done,
  output div_state_e state,
  output logic       load,
  output logic       step,
  output logic       finish,
  output logic       out_valid
);

  div_state_e state_d;

  // Next-state and command decode.
  always_comb begin
    state_d = state;
    load    = 1'b0;
    step    = 1'b0;
    finish  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (in_valid) begin
          load    = 1'b1;
          state_d = ST_COMP;
        end
      end
      ST_COMP: begin
        if (done) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          step = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State and pulse registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
    end else begin
      state     <= state_d;
      out_valid <= finish;
    end
  end

endmodule

// File: rtl/lopdiv_top.sv
// Multi-cycle unsigned divider that skips runs of zero quotient bits.
module lopdiv_top
  import lopdiv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              out_valid,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder
);

  div_state_e        state_q;
  logic              load;
  logic              step;
  logic              finish;
  logic              done;

  logic [DATA_W-1:0] rem_q;
  logic [DATA_W-1:0] dvs_q;
  logic [DATA_W-1:0] quo_q;
  logic [DATA_W-1:0] rem_d;
  logic [DATA_W-1:0] dvs_d;
  logic [DATA_W-1:0] quo_d;
  logic              rem_en;
  logic              dvs_en;
  logic              quo_en;

  logic [DATA_W-1:0] rem_next;
  logic [DATA_W-1:0] qbit;
  logic              fits;
  logic              dvs_zero;

  lopdiv_step #(.DATA_W(DATA_W)) u_step (
    .rem      (rem_q),
    .dvs      (dvs_q),
    .rem_next (rem_next),
    .qbit     (qbit),
    .fits     (fits),
    .dvs_zero (dvs_zero)
  );

  assign done = dvs_zero || !fits;

  lopdiv_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .done      (done),
    .state     (state_q),
    .load      (load),
    .step      (step),
    .finish    (finish),
    .out_valid (out_valid)
  );

  // Datapath next values and clock enables.
  always_comb begin
    dvs_en = load;
    dvs_d  = divisor;

    rem_en = load || step;
    rem_d  = load ? dividend : rem_next;

    quo_en = load || step || (finish && dvs_zero);
    if (load) begin
      quo_d = '0;
    end else if (finish) begin
      quo_d = '1;                      // saturated result for a zero divisor
    end else begin
      quo_d = quo_q | qbit;
    end
  end

  // Datapath registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
    end else begin
      if (rem_en) rem_q <= rem_d;
      if (dvs_en) dvs_q <= dvs_d;
      if (quo_en) quo_q <= quo_d;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/lopdiv_checks.sv
// Temporal properties of the divider, attached to the top module by bind.
module lopdiv_checks
  import lopdiv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input div_state_e        state,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] quotient,
  input logic [DATA_W-1:0] remainder,
  input logic [DATA_W-1:0] dvs
);

  // R1: acceptance enters compute with a cleared quotient.
  p_load_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && in_valid) |=> (state == ST_COMP && quotient == '0));

  // R2: a finished nonzero division leaves a remainder below the divisor.
  p_result_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dvs == '0 || remainder < dvs));

  // R3: a reducing cycle adds one fresh quotient bit and shrinks the remainder.
  p_step_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMP && dvs != '0 && remainder >= dvs) |=>
      (remainder < $past(remainder)) && (quotient > $past(quotient)) &&
      ($countones(quotient ^ $past(quotient)) == 1));

  // R5: the completion pulse lasts one cycle.
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: the controller is idle while the pulse is high.
  p_idle_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> state == ST_IDLE);

  // R6: the captured divisor holds through and after every compute cycle.
  p_divisor_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMP) |=> $stable(dvs));

  // R7: a zero divisor finishes on the next edge with a saturated quotient.
  p_zero_divisor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMP && dvs == '0) |=> (out_valid && (&quotient)));

  // R9: no completion pulse is visible while reset is applied.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert (!out_valid);
    end
  end

endmodule

bind lopdiv_top lopdiv_checks #(.DATA_W(DATA_W)) u_lopdiv_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state_q),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .quotient  (quotient),
  .remainder (remainder),
  .dvs       (dvs_q)
);

// File: tb/lopdiv_top_bench.sv
module lopdiv_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         out_valid;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lopdiv_top #(.DATA_W(W)) u_lopdiv_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dividend  (dividend),
    .divisor   (divisor),
    .out_valid (out_valid),
    .quotient  (quotient),
    .remainder (remainder)
  );

  function automatic int popc(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Called at a falling edge. Offers one pair, follows it to completion and
  // returns at the falling edge where out_valid is high (or after a timeout).
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit noise, input string req);
    int           cyc;
    int           exp_lat;
    logic [W-1:0] exp_q;
    logic [W-1:0] exp_r;
    in_valid = 1'b1;
    dividend = a;
    divisor  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    do begin
      if (noise) begin
        in_valid = 1'($urandom);
        dividend = W'($urandom);
        divisor  = W'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end while (!out_valid && cyc < W + 4);
    in_valid = 1'b0;
    if (b == '0) begin
      exp_q   = '1;
      exp_r   = a;
      exp_lat = 1;
    end else begin
      exp_q   = a / b;
      exp_r   = a % b;
      exp_lat = popc(exp_q) + 1;
    end
    chk(out_valid == 1'b1, "R4", "out_valid seen", longint'(out_valid), 1);
    chk(cyc == exp_lat, "R4", "latency in edges", cyc, exp_lat);
    chk(quotient == exp_q, req, "quotient", longint'(quotient), longint'(exp_q));
    chk(remainder == exp_r, req, "remainder", longint'(remainder), longint'(exp_r));
  endtask

  // R5: one cycle later the pulse must be gone.
  task automatic pulse_gap();
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5", "out_valid one cycle after result", longint'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid during reset", longint'(out_valid), 0);
    chk(quotient == '0, "R9", "quotient during reset", longint'(quotient), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed cases.
    run_op(16'd100, 16'd7, 1'b0, "R2");       pulse_gap();
    run_op(16'hFFFF, 16'd1, 1'b0, "R2");      pulse_gap();   // 16 set bits
    run_op(16'h8000, 16'd3, 1'b0, "R3");      pulse_gap();   // overshoot steps
    run_op(16'd1234, 16'd1234, 1'b0, "R2");   pulse_gap();
    run_op(16'hFFFF, 16'hFFFF, 1'b0, "R2");   pulse_gap();
    run_op(16'd5, 16'd0, 1'b0, "R7");         pulse_gap();
    run_op(16'd0, 16'd0, 1'b0, "R7");         pulse_gap();
    run_op(16'd3, 16'd9, 1'b0, "R8");         pulse_gap();
    run_op(16'd0, 16'd5, 1'b0, "R8");         pulse_gap();
    // R1: a small result right after a large one shows the quotient is cleared.
    run_op(16'hFFFF, 16'd1, 1'b0, "R1");
    pulse_gap();
    run_op(16'd2, 16'd3, 1'b0, "R1");         pulse_gap();
    // R10: back-to-back, each new pair offered while out_valid is high.
    run_op(16'd50000, 16'd3, 1'b0, "R10");
    run_op(16'd777, 16'd0, 1'b0, "R10");
    run_op(16'd4095, 16'd64, 1'b0, "R10");
    pulse_gap();
    // R6: inputs toggled throughout the compute phase.
    run_op(16'hFFFF, 16'd1, 1'b1, "R6");      pulse_gap();
    run_op(16'd60001, 16'd7, 1'b1, "R6");     pulse_gap();

    // R9: reset in the middle of a long division.
    begin
      bit quiet = 1'b1;
      in_valid = 1'b1;
      dividend = 16'hFFFF;
      divisor  = 16'd1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) begin
        @(posedge clk);
        @(negedge clk);
      end
      rst_n = 1'b0;
      #1;
      chk(out_valid == 1'b0, "R9", "out_valid right after reset", longint'(out_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (out_valid) quiet = 1'b0;
      end
      chk(quiet, "R9", "abandoned operation stays silent", longint'(quiet), 1);
      run_op(16'd999, 16'd10, 1'b0, "R9");
      pulse_gap();
    end

    // Random operands, with a mix of divisor ranges and back-to-back issue.
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      int           sel;
      a   = W'($urandom);
      sel = int'($urandom % 4);
      case (sel)
        0: b = W'($urandom % 8);
        1: b = W'($urandom % 256);
        2: b = W'($urandom);
        default: b = a >> ($urandom % 4);
      endcase
      run_op(a, b, (n % 5) == 4, "R2");
      if ((n % 3) == 0) pulse_gap();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule